// File: doc/BRIEF.md
# Directory Sharer Tracker

This block is the coherence directory of one shared last-level cache slice. Requests arrive one at a time over a valid/ready handshake. Each request carries a line address, the ID of the requesting core and a request kind. The block looks up a small direct-mapped directory. Each entry holds a tag, a line state, a 64-bit vector of data sharers and a separate 64-bit vector of instruction-cache sharers. From that entry the block works out which private copies must be removed.

The block sends one invalidation message per target core, one per cycle, in ascending core order. It counts the acknowledgements that come back. Only after the last acknowledgement does it issue a single grant to the requester. Because the slice is the point of coherence, only one request is in flight at a time, and grants come out in acceptance order.

Data loads remove every instruction-cache copy of the line before they are granted. Stores leave the requester as the sole exclusive owner. A directory conflict invalidates every recorded sharer of the displaced line, because the cache includes the private caches.

Top module: `dir_sharer_tracker`

## Requirements
- R1: After a synchronous active-high reset, `req_ready` is 1, and `inv_valid` and `gnt_valid` are 0.
- R2: The request kind is encoded on `req_kind` as 0 = data load, 1 = instruction fetch, 2 = store, 3 = eviction notice. A data load that hits a line invalidates every core recorded as an instruction-cache sharer of it, the requester included. All of these messages carry the line address. The requester then becomes a data sharer, and the line has no instruction sharers.
- R3: A store that hits invalidates every other data sharer and every instruction sharer. The grant then has `gnt_excl` = 1, and the entry records the requester as the only sharer and owner. Grants to every other kind have `gnt_excl` = 0.
- R4: The invalidations for one request go out on consecutive cycles, one per cycle, in strictly ascending `inv_core` order.
- R5: While a request is in progress, `req_ready` is 0 and no new request is accepted. `inv_valid` is never 1 while `req_ready` is 1.
- R6: The grant for a request appears only after every invalidation sent for it has been acknowledged. `inv_ack` is a one-cycle pulse per acknowledgement.
- R7: The directory entry is selected by the low log2(depth) bits of the line address, and the rest of the address is the tag. A load, fetch or store that misses on a valid entry first invalidates every data and instruction sharer of the displaced line, using that line's address. It then installs the new line with only the requester recorded.
- R8: An instruction fetch adds the requester as an instruction sharer and sends no invalidation. An eviction notice removes the requester from both vectors and sends no invalidation. An entry left with no sharers becomes invalid. An eviction notice that misses changes nothing.
- R9: Every accepted request receives exactly one one-cycle grant. Grants come in acceptance order and carry the requester's ID and line address.
- R10: A request that needs no invalidation is granted with `gnt_valid` high in the second cycle after the accepting clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Line address (64-byte lines) |
| req_core | input | log2(N_SHARERS) | Requesting core ID |
| req_kind | input | 2 | 0 load, 1 fetch, 2 store, 3 eviction notice |
| inv_valid | output | 1 | Invalidation message valid this cycle |
| inv_core | output | log2(N_SHARERS) | Core whose copy is removed |
| inv_addr | output | ADDR_W | Line being invalidated |
| inv_ack | input | 1 | One acknowledgement per pulse |
| gnt_valid | output | 1 | Grant pulse |
| gnt_core | output | log2(N_SHARERS) | Granted core |
| gnt_addr | output | ADDR_W | Granted line |
| gnt_excl | output | 1 | Grant gives exclusive ownership (store) |

## Verification
Two events can land in the same cycle: issuing the next invalidation and receiving an acknowledgement for an earlier one. Both touch the outstanding count that gates the grant. The bench provokes this by acknowledging with zero and one cycle of delay during long bursts, up to a full 64-sharer store. It also uses longer delays, so that acknowledgements trail after the last message. It then judges the overlap by checking the grant against a model of the directory. The grant must carry the right fields, it must never appear while a message is still unacknowledged, and it must not be missing once the count has drained.

// File: rtl/dst_pkg.sv
package dst_pkg;
  typedef enum logic [1:0] {
    RK_LOAD   = 2'd0,
    RK_IFETCH = 2'd1,
    RK_STORE  = 2'd2,
    RK_EVICT  = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_LOOK = 2'd1,
    FS_SEND = 2'd2
  } flow_st_e;
endpackage

// File: rtl/dst_dir_store.sv
module dst_dir_store #(
  parameter int N      = 64,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [TAG_W-1:0]   rd_tag,
  output logic [N-1:0]       rd_dsh,
  output logic [N-1:0]       rd_ish,
  output dst_pkg::line_st_e  rd_st,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [N-1:0]       wr_dsh,
  input  logic [N-1:0]       wr_ish,
  input  dst_pkg::line_st_e  wr_st
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int WORD_W = TAG_W + 2 * N;

  // Tag and sharer vectors live in a plain RAM; states stay in resettable flops.
  logic [WORD_W-1:0]  ram [DEPTH];
  logic [WORD_W-1:0]  rd_word;
  dst_pkg::line_st_e  st_r [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) ram[wr_idx] <= {wr_tag, wr_dsh, wr_ish};
    if (rd_en) rd_word <= ram[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) st_r[i] <= dst_pkg::LS_INV;
      rd_st <= dst_pkg::LS_INV;
    end else begin
      if (wr_en) st_r[wr_idx] <= wr_st;
      if (rd_en) rd_st <= st_r[rd_idx];
    end
  end

  assign rd_tag = rd_word[WORD_W-1 -: TAG_W];
  assign rd_dsh = rd_word[2*N-1 -: N];
  assign rd_ish = rd_word[N-1:0];
endmodule

// File: rtl/dst_next_state.sv
module dst_next_state #(
  parameter int N      = 64,
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 2,
  localparam int CORE_W = $clog2(N),
  localparam int TAG_W  = ADDR_W - IDX_W
) (
  input  dst_pkg::req_kind_e kind,
  input  logic [CORE_W-1:0]  core,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [TAG_W-1:0]   cur_tag,
  input  logic [N-1:0]       cur_dsh,
  input  logic [N-1:0]       cur_ish,
  input  dst_pkg::line_st_e  cur_st,
  output logic [N-1:0]       inv_mask,
  output logic [ADDR_W-1:0]  inv_line,
  output logic               upd,
  output logic [TAG_W-1:0]   new_tag,
  output logic [N-1:0]       new_dsh,
  output logic [N-1:0]       new_ish,
  output dst_pkg::line_st_e  new_st,
  output logic               excl
);
  import dst_pkg::*;

  logic [N-1:0]     me;
  logic [TAG_W-1:0] req_tag;
  logic             hit;

  assign me      = {{(N-1){1'b0}}, 1'b1} << core;
  assign req_tag = addr[ADDR_W-1:IDX_W];
  assign hit     = (cur_st != LS_INV) && (cur_tag == req_tag);
  assign excl    = (kind == RK_STORE);

  always_comb begin
    inv_mask = '0;
    inv_line = addr;
    upd      = 1'b0;
    new_tag  = cur_tag;
    new_dsh  = cur_dsh;
    new_ish  = cur_ish;
    new_st   = cur_st;
    if (hit) begin
      upd = 1'b1;
      unique case (kind)
        RK_LOAD: begin
          inv_mask = cur_ish;
          new_dsh  = cur_dsh | me;
          new_ish  = '0;
          new_st   = LS_SHR;
        end
        RK_IFETCH: begin
          new_ish = cur_ish | me;
          new_st  = LS_SHR;
        end
        RK_STORE: begin
          inv_mask = (cur_dsh & ~me) | cur_ish;
          new_dsh  = me;
          new_ish  = '0;
          new_st   = LS_EXC;
        end
        default: begin
          new_dsh = cur_dsh & ~me;
          new_ish = cur_ish & ~me;
          if (((cur_dsh | cur_ish) & ~me) == '0) new_st = LS_INV;
        end
      endcase
    end else if (kind != RK_EVICT) begin
      upd      = 1'b1;
      inv_mask = (cur_st != LS_INV) ? (cur_dsh | cur_ish) : '0;
      inv_line = {cur_tag, addr[IDX_W-1:0]};
      new_tag  = req_tag;
      new_dsh  = (kind == RK_IFETCH) ? '0 : me;
      new_ish  = (kind == RK_IFETCH) ? me : '0;
      new_st   = (kind == RK_STORE) ? LS_EXC : LS_SHR;
    end
  end
endmodule

// File: rtl/dst_inv_issuer.sv
module dst_inv_issuer #(
  parameter int N      = 64,
  parameter int ADDR_W = 16,
  localparam int CORE_W = $clog2(N),
  localparam int CNT_W  = $clog2(N + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [N-1:0]       load_mask,
  input  logic [ADDR_W-1:0]  load_line,
  input  logic               ack,
  output logic               inv_valid,
  output logic [CORE_W-1:0]  inv_core,
  output logic [ADDR_W-1:0]  inv_addr,
  output logic               idle
);
  logic [N-1:0]      pend;
  logic [N-1:0]      low_oh;
  logic [CORE_W-1:0] low_idx;
  logic [CNT_W-1:0]  outst;
  logic              issue;

  assign low_oh = pend & (~pend + {{(N-1){1'b0}}, 1'b1});
  assign issue  = !load && (pend != '0);
  assign idle   = (pend == '0) && (outst == '0);

  always_comb begin
    low_idx = '0;
    for (int i = 0; i < N; i++) if (low_oh[i]) low_idx = CORE_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= '0;
      outst     <= '0;
      inv_valid <= 1'b0;
      inv_core  <= '0;
      inv_addr  <= '0;
    end else begin
      inv_valid <= issue;
      outst     <= outst + CNT_W'(issue) - CNT_W'(ack);
      if (load) begin
        pend     <= load_mask;
        inv_addr <= load_line;
      end else if (issue) begin
        pend     <= pend & ~low_oh;
        inv_core <= low_idx;
      end
    end
  end

  AST_INV_ASCENDING: assert property (@(posedge clk) disable iff (rst)
    inv_valid && $past(inv_valid) |-> inv_core > $past(inv_core)); // R4

  AST_ACK_HAS_OWNER: assert property (@(posedge clk) disable iff (rst)
    ack |-> outst != '0); // R6
endmodule

// File: rtl/dir_sharer_tracker.sv
module dir_sharer_tracker #(
  parameter int N_SHARERS = 64,
  parameter int ADDR_W    = 16,
  parameter int DIR_DEPTH = 4,
  localparam int CORE_W = $clog2(N_SHARERS),
  localparam int IDX_W  = $clog2(DIR_DEPTH),
  localparam int TAG_W  = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CORE_W-1:0] req_core,
  input  logic [1:0]        req_kind,
  output logic              inv_valid,
  output logic [CORE_W-1:0] inv_core,
  output logic [ADDR_W-1:0] inv_addr,
  input  logic              inv_ack,
  output logic              gnt_valid,
  output logic [CORE_W-1:0] gnt_core,
  output logic [ADDR_W-1:0] gnt_addr,
  output logic              gnt_excl
);
  import dst_pkg::*;

  flow_st_e          fsm;
  logic [ADDR_W-1:0] rq_addr;
  logic [CORE_W-1:0] rq_core;
  req_kind_e         rq_kind;
  logic              rq_excl;
  logic              accept;

  logic [TAG_W-1:0]     d_tag, n_tag;
  logic [N_SHARERS-1:0] d_dsh, d_ish, n_dsh, n_ish, n_mask;
  line_st_e             d_st, n_st;
  logic [ADDR_W-1:0]    n_line;
  logic                 n_upd, n_excl, iss_idle;

  assign req_ready = (fsm == FS_IDLE);
  assign accept    = req_valid && req_ready;

  dst_dir_store #(.N(N_SHARERS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst(rst),
    .rd_en(accept), .rd_idx(req_addr[IDX_W-1:0]),
    .rd_tag(d_tag), .rd_dsh(d_dsh), .rd_ish(d_ish), .rd_st(d_st),
    .wr_en((fsm == FS_LOOK) && n_upd), .wr_idx(rq_addr[IDX_W-1:0]),
    .wr_tag(n_tag), .wr_dsh(n_dsh), .wr_ish(n_ish), .wr_st(n_st)
  );

  dst_next_state #(.N(N_SHARERS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_next (
    .kind(rq_kind), .core(rq_core), .addr(rq_addr),
    .cur_tag(d_tag), .cur_dsh(d_dsh), .cur_ish(d_ish), .cur_st(d_st),
    .inv_mask(n_mask), .inv_line(n_line), .upd(n_upd),
    .new_tag(n_tag), .new_dsh(n_dsh), .new_ish(n_ish), .new_st(n_st),
    .excl(n_excl)
  );

  dst_inv_issuer #(.N(N_SHARERS), .ADDR_W(ADDR_W)) u_issue (
    .clk(clk), .rst(rst),
    .load(fsm == FS_LOOK), .load_mask(n_mask), .load_line(n_line),
    .ack(inv_ack),
    .inv_valid(inv_valid), .inv_core(inv_core), .inv_addr(inv_addr),
    .idle(iss_idle)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm       <= FS_IDLE;
      rq_addr   <= '0;
      rq_core   <= '0;
      rq_kind   <= RK_LOAD;
      rq_excl   <= 1'b0;
      gnt_valid <= 1'b0;
      gnt_core  <= '0;
      gnt_addr  <= '0;
      gnt_excl  <= 1'b0;
    end else begin
      gnt_valid <= 1'b0;
      unique case (fsm)
        FS_IDLE: if (accept) begin
          rq_addr <= req_addr;
          rq_core <= req_core;
          rq_kind <= req_kind_e'(req_kind);
          fsm     <= FS_LOOK;
        end
        FS_LOOK: begin
          rq_excl <= n_excl;
          fsm     <= FS_SEND;
        end
        default: if (iss_idle) begin
          gnt_valid <= 1'b1;
          gnt_core  <= rq_core;
          gnt_addr  <= rq_addr;
          gnt_excl  <= rq_excl;
          fsm       <= FS_IDLE;
        end
      endcase
    end
  end

  AST_QUIET_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !inv_valid); // R5

  AST_GRANT_AFTER_ACKS: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> iss_idle); // R6

  AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |=> !gnt_valid); // R9
endmodule

// File: tb/dir_sharer_tracker_bench.sv
`timescale 1ns/1ps
module dir_sharer_tracker_bench;
  localparam int N = 64;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [5:0] req_core = '0;
  logic [1:0] req_kind = '0;
  logic inv_valid;
  logic [5:0] inv_core;
  logic [AW-1:0] inv_addr;
  logic inv_ack = 1'b0;
  logic gnt_valid;
  logic [5:0] gnt_core;
  logic [AW-1:0] gnt_addr;
  logic gnt_excl;

  always #2.5 clk = ~clk;

  dir_sharer_tracker u_dir_sharer_tracker (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_core(req_core), .req_kind(req_kind),
    .inv_valid(inv_valid), .inv_core(inv_core), .inv_addr(inv_addr),
    .inv_ack(inv_ack),
    .gnt_valid(gnt_valid), .gnt_core(gnt_core), .gnt_addr(gnt_addr),
    .gnt_excl(gnt_excl)
  );

  typedef struct { int seq; int core; int addr; string rq; } inv_t;
  typedef struct { int seq; int core; int addr; bit excl; int at; bit noinv; } gnt_t;

  int nchk = 0, nfail = 0, cyc = 0, seq = 0, ack_dly = 0;
  bit done = 0;
  inv_t exp_inv[$];
  gnt_t exp_gnt[$];
  int   ackq[$];

  int          m_st [4];
  int          m_tag[4];
  logic [63:0] m_d  [4];
  logic [63:0] m_i  [4];

  bit prev_inv = 0;
  int prev_core = 0, prev_seq = 0;

  task automatic chk(input bit ok, input string r, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Reference directory: state 0 invalid, 1 shared, 2 exclusive.
  function automatic void model(input int a, input int c, input int k, input int at);
    int idx = a % 4;
    int tg = a / 4;
    logic [63:0] me = 64'd1 << c;
    logic [63:0] mask = '0;
    int line = a;
    string rq = "R8";
    bit hit = (m_st[idx] != 0) && (m_tag[idx] == tg);
    seq++;
    if (hit) begin
      if (k == 0) begin
        mask = m_i[idx]; m_d[idx] |= me; m_i[idx] = '0; m_st[idx] = 1; rq = "R2";
      end else if (k == 1) begin
        m_i[idx] |= me; m_st[idx] = 1;
      end else if (k == 2) begin
        mask = (m_d[idx] & ~me) | m_i[idx]; m_d[idx] = me; m_i[idx] = '0;
        m_st[idx] = 2; rq = "R3";
      end else begin
        m_d[idx] &= ~me; m_i[idx] &= ~me;
        if ((m_d[idx] | m_i[idx]) == '0) m_st[idx] = 0;
      end
    end else if (k != 3) begin
      if (m_st[idx] != 0) begin
        mask = m_d[idx] | m_i[idx];
        line = m_tag[idx] * 4 + idx;
        rq = "R7";
      end
      m_tag[idx] = tg;
      m_d[idx] = (k == 1) ? '0 : me;
      m_i[idx] = (k == 1) ? me : '0;
      m_st[idx] = (k == 2) ? 2 : 1;
    end
    for (int i = 0; i < N; i++)
      if (mask[i]) exp_inv.push_back('{seq, i, line, rq});
    exp_gnt.push_back('{seq, c, a, (k == 2), at, (mask == '0)});
  endfunction

  task automatic send(input int a, input int c, input int k);
    bit r;
    int c0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = AW'(a); req_core = 6'(c); req_kind = 2'(k);
    forever begin
      r = req_ready; c0 = cyc;
      @(posedge clk);
      if (r) break;
      @(negedge clk);
    end
    model(a, c, k, c0 + 3);
  endtask

  task automatic drain();
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 400 && (exp_gnt.size() != 0 || !req_ready); i++) @(negedge clk);
  endtask

  // Monitor and acknowledgement responder, away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (inv_valid) begin
        chk(!req_ready, "R5", "ready during invalidation", req_ready, 0);
        if (exp_inv.size() == 0) begin
          chk(0, "R9", "unexpected invalidation core", inv_core, 0);
        end else begin
          chk(inv_core == exp_inv[0].core, exp_inv[0].rq, "inv core", inv_core, exp_inv[0].core);
          chk(inv_addr == AW'(exp_inv[0].addr), exp_inv[0].rq, "inv line", inv_addr, exp_inv[0].addr);
          if (prev_inv) chk(inv_core > prev_core, "R4", "ascending order", inv_core, prev_core);
          prev_seq = exp_inv[0].seq;
          void'(exp_inv.pop_front());
        end
        prev_core = inv_core;
      end else if (prev_inv) begin
        chk(!(exp_inv.size() != 0 && exp_inv[0].seq == prev_seq), "R4",
            "gap inside burst", exp_inv.size(), 0);
      end
      prev_inv = inv_valid;
      if (gnt_valid) begin
        if (exp_gnt.size() == 0) begin
          chk(0, "R9", "unexpected grant", gnt_core, 0);
        end else begin
          chk(!(exp_inv.size() != 0 && exp_inv[0].seq == exp_gnt[0].seq), "R2",
              "grant before all invalidations", exp_inv.size(), 0);
          chk(ackq.size() == 0 && !inv_ack, "R6", "grant with unacked messages", ackq.size(), 0);
          chk(gnt_core == exp_gnt[0].core, "R9", "grant core", gnt_core, exp_gnt[0].core);
          chk(gnt_addr == AW'(exp_gnt[0].addr), "R9", "grant line", gnt_addr, exp_gnt[0].addr);
          chk(gnt_excl == exp_gnt[0].excl, "R3", "grant exclusive", gnt_excl, exp_gnt[0].excl);
          if (exp_gnt[0].noinv) chk(cyc == exp_gnt[0].at, "R10", "grant latency", cyc, exp_gnt[0].at);
          void'(exp_gnt.pop_front());
        end
      end
      if (inv_valid) ackq.push_back(cyc + ack_dly);
      if (ackq.size() != 0 && ackq[0] <= cyc) begin
        void'(ackq.pop_front());
        inv_ack = 1'b1;
      end else begin
        inv_ack = 1'b0;
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R9 watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_tag[i] = 0; m_d[i] = '0; m_i[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    chk(!inv_valid && !gnt_valid, "R1", "outputs quiet in reset", {inv_valid, gnt_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1 && !inv_valid && !gnt_valid, "R1", "state after reset",
        {req_ready, inv_valid, gnt_valid}, 3'b100);

    // R10 and R8: no-invalidation requests
    ack_dly = 0;
    send('h10, 3, 0);
    send('h10, 5, 1); send('h10, 1, 1); send('h10, 63, 1);
    // R2: load purges instruction copies, acks overlapping issue
    send('h10, 7, 0);
    send('h10, 0, 0);
    // R3: store, slow acks
    ack_dly = 3;
    send('h10, 3, 2);
    send('h10, 9, 2);
    send('h10, 2, 1); send('h10, 4, 0);
    // R8: eviction notices empty the entry
    send('h10, 4, 3); send('h10, 9, 3);
    send('h10, 6, 0);
    // R7: conflict on entry 0
    ack_dly = 1;
    send('h14, 11, 1);
    send('h10, 12, 0);
    send('h33, 5, 3);
    drain();
    // R4: all 64 instruction sharers then a store
    for (int c = 0; c < N; c++) send('h21, c, 1);
    ack_dly = 0;
    send('h21, 40, 2);
    drain();
    for (int n = 0; n < 60; n++) begin
      int lines[5] = '{'h10, 'h14, 'h21, 'h25, 'h33};
      ack_dly = $urandom % 4;
      send(lines[$urandom % 5], $urandom % N, $urandom % 4);
    end
    drain();
    chk(exp_gnt.size() == 0, "R9", "grants outstanding at end", exp_gnt.size(), 0);
    chk(exp_inv.size() == 0, "R7", "invalidations outstanding at end", exp_inv.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule